// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of a small set of one-word cache lines on behalf of one processor. Each line is Modified, Exclusive, Shared or Invalid. The local processor presents read and write requests. The block answers hits at once. It asks memory for a fill on a read miss. It stalls on a write that needs ownership until every peer cache has confirmed an invalidate. At the same time the block watches the read and invalidate messages of peer caches and adjusts its own lines to match.

Coherence traffic is message based. A single outgoing message port carries four message types: fetch requests, invalidate broadcasts, invalidate acknowledgements and write-back data. Memory is modelled only as a fill response on a dedicated input, which carries a flag raised when some peer also holds the line. Acknowledgements arrive on a per-peer vector, so several peers may answer in the same cycle.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code I=0, S=1, E=2, M=3). `req_ready` is high while no snoop is presented, and `msg_valid` and `rsp_valid` are low.
- R2: A read of a line in M, E or S raises `rsp_valid` in the cycle after acceptance, with the stored word and the unchanged state. No message is sent.
- R3: A read of an Invalid line sends a fetch message (op code 0, with the line number) in the cycle after acceptance. The block then stalls until `fill_valid`. The line is filled as E when `fill_shared` is low and as S when it is high, and the response follows in the cycle after the fill.
- R4: A write to a line in M or E completes in the cycle after acceptance. The line becomes M with the new word, and no message is sent.
- R5: A write to a line in S or I sends an invalidate message (op code 1, carrying the write word). The block stalls while it counts the set bits of `ack_in`. In the cycle where the count reaches NPEERS the line becomes M with the new word, and the response appears one cycle later.
- R6: A snooped invalidate moves the named line to I and sends an acknowledgement message (op code 2, with the line number) in the next cycle, whatever the line's prior state.
- R7: A snooped read of an M line sends a write-back message (op code 3) with the stored word and moves the line to S. A snooped read of an E line moves it to S and sends nothing. A snooped read of an S or I line changes nothing and sends nothing.
- R8: `req_ready` is low in any cycle with `snoop_valid` high and while a fetch or invalidate is outstanding. A request presented then is not taken.
- R9: Acknowledgements that arrive while no invalidate is outstanding are ignored and do not count toward a later invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | IW | Line index of the request |
| req_wdata | input | DW | Write word |
| req_ready | output | 1 | Request taken this cycle (low = stall) |
| rsp_valid | output | 1 | Request completed |
| rsp_rdata | output | DW | Line word after the request |
| rsp_state | output | 2 | Line state after the request |
| snoop_valid | input | 1 | Peer message observed |
| snoop_inv | input | 1 | 1 = peer invalidate, 0 = peer read |
| snoop_line | input | IW | Line index of the peer message |
| ack_in | input | NPEERS | One bit per peer acknowledging an invalidate |
| fill_valid | input | 1 | Memory fill word present |
| fill_data | input | DW | Fill word |
| fill_shared | input | 1 | Some peer also holds the line |
| msg_valid | output | 1 | Outgoing message, one-cycle pulse |
| msg_op | output | 2 | 0 fetch, 1 invalidate, 2 acknowledge, 3 write-back |
| msg_line | output | IW | Line index of the message |
| msg_data | output | DW | Message word |

## Verification
The bench builds the block with its defaults: four lines, three peers and an eight-bit word. With three peers the acknowledgement count can be split over cycles (two bits, then one), delivered all at once, or preceded by stray acknowledgements that must not count. Four lines leave one line untouched, so the bench can show that traffic on the other lines never disturbs it. Snoops are also injected while an invalidate is outstanding and in the same cycle as a request.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int NLINES = 4,
  parameter int NPEERS = 3,
  parameter int DW     = 8,
  localparam int IW    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IW-1:0]     req_line,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [1:0]        rsp_state,
  input  logic              snoop_valid,
  input  logic              snoop_inv,
  input  logic [IW-1:0]     snoop_line,
  input  logic [NPEERS-1:0] ack_in,
  input  logic              fill_valid,
  input  logic [DW-1:0]     fill_data,
  input  logic              fill_shared,
  output logic              msg_valid,
  output logic [1:0]        msg_op,
  output logic [IW-1:0]     msg_line,
  output logic [DW-1:0]     msg_data
);
  localparam int CW = $clog2(NPEERS + 1);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] OP_FETCH = 2'd0, OP_INVAL = 2'd1, OP_ACK = 2'd2, OP_WB = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_FILL, PH_INV} phase_t;

  phase_t           ph;
  logic [1:0]       lstate [NLINES];
  logic [DW-1:0]    ldata  [NLINES];
  logic [IW-1:0]    pend_line;
  logic [DW-1:0]    pend_word;
  logic [CW-1:0]    ack_cnt;

  assign req_ready = (ph == PH_IDLE) && !snoop_valid;

  wire        take    = req_valid && req_ready;
  wire [1:0]  cur     = lstate[req_line];
  wire [1:0]  snp_cur = lstate[snoop_line];
  wire        rd_hit  = take && !req_write && (cur != ST_I);
  wire        rd_miss = take && !req_write && (cur == ST_I);
  wire        wr_own  = take && req_write && (cur == ST_M || cur == ST_E);
  wire        wr_inv  = take && req_write && (cur == ST_S || cur == ST_I);

  wire [CW-1:0] ack_sum  = ack_cnt + CW'($countones(ack_in));
  wire          inv_done = (ph == PH_INV) && (ack_sum == CW'(NPEERS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      pend_line <= '0;
      pend_word <= '0;
      ack_cnt   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_state <= ST_I;
      msg_valid <= 1'b0;
      msg_op    <= OP_FETCH;
      msg_line  <= '0;
      msg_data  <= '0;
      for (int i = 0; i < NLINES; i++) begin
        lstate[i] <= ST_I;
        ldata[i]  <= '0;
      end
    end else begin
      msg_valid <= 1'b0;
      rsp_valid <= 1'b0;

      if (snoop_valid) begin
        if (snoop_inv) begin
          lstate[snoop_line] <= ST_I;
          msg_valid <= 1'b1;
          msg_op    <= OP_ACK;
          msg_line  <= snoop_line;
          msg_data  <= '0;
        end else if (snp_cur == ST_M) begin
          lstate[snoop_line] <= ST_S;
          msg_valid <= 1'b1;
          msg_op    <= OP_WB;
          msg_line  <= snoop_line;
          msg_data  <= ldata[snoop_line];
        end else if (snp_cur == ST_E) begin
          lstate[snoop_line] <= ST_S;
        end
      end

      case (ph)
        PH_IDLE: begin
          if (rd_hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= ldata[req_line];
            rsp_state <= cur;
          end
          if (wr_own) begin
            lstate[req_line] <= ST_M;
            ldata[req_line]  <= req_wdata;
            rsp_valid <= 1'b1;
            rsp_rdata <= req_wdata;
            rsp_state <= ST_M;
          end
          if (rd_miss || wr_inv) begin
            pend_line <= req_line;
            pend_word <= req_wdata;
            ack_cnt   <= '0;
            msg_valid <= 1'b1;
            msg_op    <= rd_miss ? OP_FETCH : OP_INVAL;
            msg_line  <= req_line;
            msg_data  <= rd_miss ? '0 : req_wdata;
            ph        <= rd_miss ? PH_FILL : PH_INV;
          end
        end
        PH_FILL: begin
          if (fill_valid) begin
            lstate[pend_line] <= fill_shared ? ST_S : ST_E;
            ldata[pend_line]  <= fill_data;
            rsp_valid <= 1'b1;
            rsp_rdata <= fill_data;
            rsp_state <= fill_shared ? ST_S : ST_E;
            ph        <= PH_IDLE;
          end
        end
        PH_INV: begin
          ack_cnt <= ack_sum;
          if (inv_done) begin
            lstate[pend_line] <= ST_M;
            ldata[pend_line]  <= pend_word;
            rsp_valid <= 1'b1;
            rsp_rdata <= pend_word;
            rsp_state <= ST_M;
            ack_cnt   <= '0;
            ph        <= PH_IDLE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  a_r8_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |-> !req_ready);

  a_r5_ack_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cnt <= CW'(NPEERS));

  a_r6_inv_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_inv) |=> (msg_valid && msg_op == OP_ACK));

  a_r2_hit_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && cur != ST_I)
      |=> (rsp_valid && rsp_state == $past(cur) && !(msg_valid && msg_op != OP_ACK && msg_op != OP_WB)));

  a_r3_fill_state: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FILL && fill_valid) |=> (rsp_valid && (rsp_state == ST_S || rsp_state == ST_E)));

  a_r5_inval_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (cur == ST_S || cur == ST_I))
      |=> (msg_valid && msg_op == OP_INVAL && ph == PH_INV));
endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;
  localparam int NL = 4, NP = 3, DW = 8, IW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [IW-1:0] req_line = 0;
  logic [DW-1:0] req_wdata = 0;
  logic req_ready, rsp_valid, msg_valid;
  logic [DW-1:0] rsp_rdata, msg_data;
  logic [1:0] rsp_state, msg_op;
  logic [IW-1:0] msg_line;
  logic snoop_valid = 0, snoop_inv = 0;
  logic [IW-1:0] snoop_line = 0;
  logic [NP-1:0] ack_in = 0;
  logic fill_valid = 0, fill_shared = 0;
  logic [DW-1:0] fill_data = 0;

  int nvec = 0, nbad = 0;
  bit done = 0;

  mesi_line_ctrl #(.NLINES(NL), .NPEERS(NP), .DW(DW)) i_mesi_line_ctrl (
    .clk, .rst_n, .req_valid, .req_write, .req_line, .req_wdata, .req_ready,
    .rsp_valid, .rsp_rdata, .rsp_state, .snoop_valid, .snoop_inv, .snoop_line,
    .ack_in, .fill_valid, .fill_data, .fill_shared, .msg_valid, .msg_op,
    .msg_line, .msg_data);

  always #2 clk = ~clk;

  task automatic check(string rq, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic issue(bit w, int line, int d);
    @(negedge clk);
    check("R8 ready before request", req_ready, 1);
    req_valid = 1; req_write = w; req_line = IW'(line); req_wdata = DW'(d);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic fill(int d, bit sh);
    fill_valid = 1; fill_data = DW'(d); fill_shared = sh;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic acks(int v);
    ack_in = NP'(v);
    @(negedge clk);
    ack_in = 0;
  endtask

  task automatic snoop(bit inv, int line);
    snoop_valid = 1; snoop_inv = inv; snoop_line = IW'(line);
    @(negedge clk);
    snoop_valid = 0;
  endtask

  task automatic read_hit(string rq, int line, int d, int st);
    issue(0, line, 0);
    check({rq, " hit rsp"}, rsp_valid, 1);
    check({rq, " hit data"}, rsp_rdata, d);
    check({rq, " hit state"}, rsp_state, st);
    check({rq, " hit no msg"}, msg_valid, 0);
  endtask

  task automatic read_miss(string rq, int line, int d, bit sh);
    issue(0, line, 0);
    check({rq, " fetch sent"}, msg_valid, 1);
    check({rq, " fetch op"}, msg_op, 0);
    check({rq, " fetch line"}, msg_line, line);
    check({rq, " stalled"}, req_ready, 0);
    check({rq, " no early rsp"}, rsp_valid, 0);
    fill(d, sh);
    check({rq, " fill rsp"}, rsp_valid, 1);
    check({rq, " fill data"}, rsp_rdata, d);
    check({rq, " fill state"}, rsp_state, sh ? 1 : 2);
  endtask

  task automatic t_reset;
    check("R1 ready", req_ready, 1);
    check("R1 msg idle", msg_valid, 0);
    check("R1 rsp idle", rsp_valid, 0);
  endtask

  task automatic t_miss_and_own_write;
    read_miss("R3 exclusive", 0, 8'h5A, 0);
    @(negedge clk);
    read_hit("R2 E", 0, 8'h5A, 2);
    issue(1, 0, 8'h11);
    check("R4 rsp", rsp_valid, 1);
    check("R4 state M", rsp_state, 3);
    check("R4 no msg", msg_valid, 0);
    read_hit("R2 M", 0, 8'h11, 3);
  endtask

  task automatic t_snoop_read_m;
    @(negedge clk);
    snoop(0, 0);
    check("R7 wb sent", msg_valid, 1);
    check("R7 wb op", msg_op, 3);
    check("R7 wb line", msg_line, 0);
    check("R7 wb data", msg_data, 8'h11);
    read_hit("R7 M to S", 0, 8'h11, 1);
  endtask

  task automatic t_write_shared_split;
    issue(1, 0, 8'h22);
    check("R5 inval sent", msg_valid, 1);
    check("R5 inval op", msg_op, 1);
    check("R5 inval data", msg_data, 8'h22);
    check("R5 stalled", req_ready, 0);
    acks(3'b011);
    check("R5 partial no rsp", rsp_valid, 0);
    check("R5 partial stall", req_ready, 0);
    acks(3'b100);
    check("R5 done rsp", rsp_valid, 1);
    check("R5 done state", rsp_state, 3);
    check("R5 ready again", req_ready, 1);
    read_hit("R5 M stored", 0, 8'h22, 3);
  endtask

  task automatic t_shared_fill_snoops;
    read_miss("R3 shared", 1, 8'h33, 1);
    snoop(0, 1);
    check("R7 S read silent", msg_valid, 0);
    read_hit("R7 S kept", 1, 8'h33, 1);
    @(negedge clk);
    snoop(1, 1);
    check("R6 ack sent", msg_valid, 1);
    check("R6 ack op", msg_op, 2);
    check("R6 ack line", msg_line, 1);
    read_miss("R6 now I", 1, 8'h44, 0);
    snoop(0, 1);
    check("R7 E read silent", msg_valid, 0);
    read_hit("R7 E to S", 1, 8'h44, 1);
  endtask

  task automatic t_write_miss_all_acks;
    issue(1, 3, 8'h77);
    check("R5 miss inval", msg_op, 1);
    check("R5 miss line", msg_line, 3);
    acks(3'b111);
    check("R5 all at once", rsp_valid, 1);
    check("R5 miss data", rsp_rdata, 8'h77);
    read_hit("R5 miss M", 3, 8'h77, 3);
  endtask

  task automatic t_stray_acks_and_snoop_wait;
    @(negedge clk);
    acks(3'b111);
    check("R9 stray ignored rsp", rsp_valid, 0);
    issue(1, 1, 8'h99);
    check("R5 S inval", msg_op, 1);
    acks(3'b001);
    check("R9 stray not counted", rsp_valid, 0);
    snoop(1, 0);
    check("R6 ack while waiting", msg_op, 2);
    check("R6 ack line 0", msg_line, 0);
    check("R8 still stalled", req_ready, 0);
    acks(3'b110);
    check("R5 done after snoop", rsp_valid, 1);
    check("R5 done state M", rsp_state, 3);
    read_miss("R6 line0 invalid", 0, 8'h12, 1);
  endtask

  task automatic t_snoop_blocks_request;
    @(negedge clk);
    snoop_valid = 1; snoop_inv = 0; snoop_line = 2;
    req_valid = 1; req_write = 1; req_line = 2; req_wdata = 8'hEE;
    #1;
    check("R8 ready low on snoop", req_ready, 0);
    @(negedge clk);
    snoop_valid = 0; req_valid = 0;
    check("R8 request not taken", rsp_valid, 0);
    check("R8 no msg", msg_valid, 0);
    read_miss("R1 untouched line I", 2, 8'h01, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss_and_own_write();
    t_snoop_read_m();
    t_write_shared_split();
    t_shared_fill_snoops();
    t_write_miss_all_acks();
    t_stray_acks_and_snoop_wait();
    t_snoop_blocks_request();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      nvec++; nbad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule